// File: doc/BRIEF.md
# Expansion ROM Scanner

This block searches a fixed span of memory for add-in ROM images after reset. The span is cut into equal windows of 2 KB, and the first window sits at linear address 0xC8000. The walk stops before the 0xE0000 region. The block reads memory one byte at a time through a simple read port. At the start of each window it looks for the two-byte marker 0x55 then 0xAA. After the marker it takes the length byte and adds up every byte of the image in an 8-bit accumulator.

When the image sums to zero, the block presents the window's base address and the address of its entry point on a valid/acknowledge pair. It then waits for the consumer. Once the consumer acknowledges, the walk moves on to the next window. When the last window is finished, a done flag rises and stays high until the next reset. The block does not hand control to any ROM. That is left to whatever consumes the reports.

Top module: `orom_scanner`

## Requirements
- R1: While rst_n is low, rd_en, rom_valid and scan_done are 0. In the first cycle after release, rd_en is 1 and rd_addr equals SCAN_BASE.
- R2: Window k starts at SCAN_BASE + k*2^WIN_SHIFT. Windows are visited in ascending order, and WIN_COUNT of them are visited in total.
- R3: A window holds an image only when offset 0 reads 0x55 and offset 1 reads 0xAA. A mismatch at offset 0 ends the window after 2 reads, and a mismatch at offset 1 ends it after 3 reads.
- R4: Offset 2 holds the image length in 512-byte units. A length of 0 ends the window after 4 reads, with no report.
- R5: The 8-bit sum, carries discarded, of all length*512 image bytes must be 0. Any other sum skips the window silently.
- R6: A valid image raises rom_valid with rom_base equal to the window base and rom_entry equal to base+3. Both hold steady, and no reads are issued, until rom_ack is sampled high. After that, rom_valid falls.
- R7: After an acknowledge, the next window's first read comes 2 cycles after the cycle in which rom_ack was sampled. This is so even when the reported image extends past that window's start.
- R8: rom_valid rises exactly length*512+1 cycles after the cycle that carries the window's offset-0 read.
- R9: After the last window, scan_done rises and stays high. From then on, no read and no report happen until reset.
- R10: Read data is taken one cycle after its address. For an image with a valid marker and a nonzero length, the reads cover exactly offsets 0 to length*512-1, one per cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the scan restarts on release |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_data | input | 8 | Byte returned one cycle after rd_en |
| rom_valid | output | 1 | A validated image is being reported |
| rom_base | output | ADDR_W | Base address of the reported image |
| rom_entry | output | ADDR_W | Entry address (base + 3) |
| rom_ack | input | 1 | Consumer has taken the report |
| scan_done | output | 1 | All windows finished |

## Verification
Each read's data is returned one cycle after its address, and the bench samples every result on the falling edge between clock edges. A report is due exactly length*512+1 cycles after the window's first read. The bench timestamps that first read on the rising edge of rd_en and compares the cycle distance on the first falling edge that shows rom_valid. After an acknowledge, rom_valid must be low at the very next falling edge, and the next window's base must be on rd_addr one falling edge later. The number of reads spent in each window is tallied against 2, 3, 4 or length*512, depending on how the window is meant to fail or pass.

// File: rtl/orom_scan_pkg.sv
// Shared definitions for the expansion ROM scanner.
// Assumes images are little-endian marked and measured in 512-byte units.
package orom_scan_pkg;

    // Controller states, in the order a passing window walks them.
    typedef enum logic [3:0] {
        ST_START,   // reset landing, no read
        ST_SIG_LO,  // read offset 0
        ST_SIG_HI,  // read offset 1, check offset 0
        ST_SIZE,    // read offset 2, check offset 1
        ST_SZCHK,   // read offset 3, capture length
        ST_BODY,    // stream remaining bytes
        ST_TAIL,    // fold last byte, judge sum
        ST_REPORT,  // hold report until acknowledged
        ST_NEXT,    // step to following window
        ST_DONE     // scan finished
    } scan_state_e;

    localparam logic [7:0] MARK_FIRST  = 8'h55;
    localparam logic [7:0] MARK_SECOND = 8'hAA;
    localparam int unsigned ENTRY_OFS  = 3;
    localparam int unsigned UNIT_SHIFT = 9;   // 512-byte length unit

endpackage

// File: rtl/orom_window_walker.sv
// Window walker: keeps the base address and index of the window being
// scanned and steps both by one stride on request.
// Assumes WIN_COUNT >= 1 and that advance is never raised on the last window.
module orom_window_walker #(
    parameter int unsigned ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] SCAN_BASE = 20'hC8000,
    parameter int unsigned WIN_SHIFT = 11,
    parameter int unsigned WIN_COUNT = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] win_base,
    output logic              win_last
);
    localparam int unsigned IDX_W = (WIN_COUNT > 1) ? $clog2(WIN_COUNT) : 1;
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << WIN_SHIFT;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WIN_COUNT - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;

    // Step index and base together when the controller moves on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= SCAN_BASE;
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
            base_q <= base_q + STRIDE;
        end
    end

    assign win_base = base_q;
    assign win_last = (idx_q == LAST_IDX);

    // R2
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(win_base));

endmodule

// File: rtl/orom_byte_summer.sv
// Byte summer: modulo-256 accumulator with a clear and an add enable.
// sum_next shows the total including the present input, so the last byte
// can be judged in the same cycle it arrives.
module orom_byte_summer #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sum_next
);
    logic [DATA_W-1:0] sum_q;

    assign sum_next = sum_q + din;

    // Clear wins over add; carries fall off the top.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (clr)    sum_q <= '0;
        else if (add_en) sum_q <= sum_next;
    end

    // R5
    sum_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en) |=> $stable(sum_q));

endmodule

// File: rtl/orom_scanner.sv
// Expansion ROM scanner top: walks the windows, checks the marker and
// length, sums each image and reports valid ones on a valid/ack pair.
// Assumes read data returns exactly one cycle after rd_en/rd_addr and that
// ADDR_W is at least as wide as the largest image offset.
module orom_scanner #(
    parameter int unsigned ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] SCAN_BASE = 20'hC8000,
    parameter int unsigned WIN_SHIFT = 11,
    parameter int unsigned WIN_COUNT = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              rom_valid,
    output logic [ADDR_W-1:0] rom_base,
    output logic [ADDR_W-1:0] rom_entry,
    input  logic              rom_ack,
    output logic              scan_done
);
    import orom_scan_pkg::*;

    localparam int unsigned OFF_W = 8 + UNIT_SHIFT;

    scan_state_e       state_q, state_d;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  last_off_q;
    logic [ADDR_W-1:0] win_base;
    logic              win_last;
    logic              advance;
    logic              sum_clr, sum_add;
    logic [7:0]        sum_next;

    orom_window_walker #(
        .ADDR_W(ADDR_W), .SCAN_BASE(SCAN_BASE),
        .WIN_SHIFT(WIN_SHIFT), .WIN_COUNT(WIN_COUNT)
    ) u_walker (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .win_base(win_base), .win_last(win_last)
    );

    orom_byte_summer #(.DATA_W(8)) u_summer (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add_en(sum_add),
        .din(rd_data), .sum_next(sum_next)
    );

    // Next-state choice from the byte returned for the previous read.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START:  state_d = ST_SIG_LO;
            ST_SIG_LO: state_d = ST_SIG_HI;
            ST_SIG_HI: state_d = (rd_data == MARK_FIRST)  ? ST_SIZE  : ST_NEXT;
            ST_SIZE:   state_d = (rd_data == MARK_SECOND) ? ST_SZCHK : ST_NEXT;
            ST_SZCHK:  state_d = (rd_data == 8'h00)       ? ST_NEXT  : ST_BODY;
            ST_BODY:   state_d = (off_q == last_off_q)    ? ST_TAIL  : ST_BODY;
            ST_TAIL:   state_d = (sum_next == 8'h00)      ? ST_REPORT : ST_NEXT;
            ST_REPORT: state_d = rom_ack ? ST_NEXT : ST_REPORT;
            ST_NEXT:   state_d = win_last ? ST_DONE : ST_SIG_LO;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_START;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    // Read offset: restarts per window, steps once per issued read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 off_q <= '0;
        else if (state_q == ST_NEXT) off_q <= '0;
        else if (rd_en)             off_q <= off_q + 1'b1;
    end

    // Last image offset, latched when the length byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_off_q <= '0;
        else if (state_q == ST_SZCHK)
            last_off_q <= OFF_W'({rd_data, {UNIT_SHIFT{1'b0}}}) - OFF_W'(1);
    end

    assign rd_en = (state_q == ST_SIG_LO) || (state_q == ST_SIG_HI) ||
                   (state_q == ST_SIZE)   || (state_q == ST_SZCHK)  ||
                   (state_q == ST_BODY);
    assign rd_addr = win_base + ADDR_W'(off_q);

    assign sum_clr = (state_q == ST_SIG_LO);
    assign sum_add = (state_q == ST_SIG_HI) || (state_q == ST_SIZE) ||
                     (state_q == ST_SZCHK)  || (state_q == ST_BODY) ||
                     (state_q == ST_TAIL);

    assign advance   = (state_q == ST_NEXT) && !win_last;
    assign rom_valid = (state_q == ST_REPORT);
    assign rom_base  = win_base;
    assign rom_entry = win_base + ADDR_W'(ENTRY_OFS);
    assign scan_done = (state_q == ST_DONE);

    // R6
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_valid && !rom_ack) |=> (rom_valid && $stable(rom_base)));

    // R6
    wait_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_valid |-> !rd_en);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (!rd_en && !rom_valid));

endmodule

// File: tb/orom_scanner_test.sv
module orom_scanner_test;
    localparam int ADDR_W = 20;
    localparam logic [ADDR_W-1:0] BASE = 20'h10000;
    localparam int WSH    = 11;
    localparam int STRIDE = 1 << WSH;
    localparam int WCNT   = 8;
    localparam int MEM_N  = WCNT * STRIDE + STRIDE;

    // Window kinds: 0 good, 1 bad first marker, 2 bad sum, 3 zero length,
    // 4 bad second marker. Entry = {kind, length}.
    localparam logic [10:0] SCEN [WCNT] = '{
        {3'd0, 8'd1}, {3'd1, 8'd0}, {3'd2, 8'd2}, {3'd3, 8'd0},
        {3'd4, 8'd0}, {3'd0, 8'd6}, {3'd0, 8'd1}, {3'd0, 8'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data = 8'h00;
    logic              rom_valid;
    logic [ADDR_W-1:0] rom_base;
    logic [ADDR_W-1:0] rom_entry;
    logic              rom_ack = 1'b0;
    logic              scan_done;

    logic [7:0] mem [MEM_N];
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int t_start = 0;
    int win_ix = -1;
    int reads [WCNT];
    int reports = 0;
    logic prev_rd = 1'b0;
    logic prev_valid = 1'b0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    orom_scanner #(
        .ADDR_W(ADDR_W), .SCAN_BASE(BASE), .WIN_SHIFT(WSH), .WIN_COUNT(WCNT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rom_valid(rom_valid), .rom_base(rom_base),
        .rom_entry(rom_entry), .rom_ack(rom_ack), .scan_done(scan_done)
    );

    // Byte-wide memory with one cycle of read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) begin
            if (rd_addr >= BASE && int'(rd_addr - BASE) < MEM_N)
                rd_data <= mem[int'(rd_addr - BASE)];
            else
                rd_data <= 8'hFF;
        end
    end

    // Monitor: window start on rd_en rising, reads per window, reports.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en && !prev_rd) begin
                t_start = cyc;
                win_ix  = win_ix + 1;
                if (win_ix < WCNT) reads[win_ix] = 1;
            end else if (rd_en && win_ix >= 0 && win_ix < WCNT) begin
                reads[win_ix] = reads[win_ix] + 1;
            end
            if (rom_valid && !prev_valid) reports = reports + 1;
        end
        prev_rd    = rd_en;
        prev_valid = rom_valid;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int kind_of(input int k);
        return int'(SCEN[k][10:8]);
    endfunction

    function automatic int len_of(input int k);
        return int'(SCEN[k][7:0]);
    endfunction

    // Build memory: filler pattern, then headers and sum fix-ups from the
    // highest window down so that nested images stay consistent.
    task automatic build_mem();
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
        for (int k = WCNT - 1; k >= 0; k--) begin
            int b;
            int span;
            logic [7:0] s;
            b = k * STRIDE;
            case (kind_of(k))
                0, 2: begin
                    mem[b] = 8'h55; mem[b+1] = 8'hAA; mem[b+2] = 8'(len_of(k));
                    span = len_of(k) * 512;
                    s = 8'h00;
                    for (int j = 0; j < span - 1; j++) s = s + mem[b+j];
                    mem[b+span-1] = 8'h00 - s + ((kind_of(k) == 2) ? 8'h01 : 8'h00);
                end
                1: mem[b] = 8'h12;
                3: begin mem[b] = 8'h55; mem[b+1] = 8'hAA; mem[b+2] = 8'h00; end
                default: begin mem[b] = 8'h55; mem[b+1] = 8'h5A; end
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int exp_reads;
        build_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!rd_en && !rom_valid && !scan_done, "R1 reset outputs",
            {rd_en, rom_valid, scan_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2 first read at the first window base
        chk(rd_en && rd_addr == BASE, "R1 first read", rd_addr, BASE);

        for (int k = 0; k < WCNT; k++) begin
            if (kind_of(k) == 0) begin
                int guard;
                guard = 0;
                while (!rom_valid && guard < 20000) begin
                    @(negedge clk);
                    guard++;
                end
                // R8 report timing from the window's first read
                chk(cyc - t_start == len_of(k) * 512 + 1, "R8 report latency",
                    cyc - t_start, len_of(k) * 512 + 1);
                // R6 / R2 base and entry of window k
                chk(rom_base == BASE + k * STRIDE, "R6 report base",
                    rom_base, BASE + k * STRIDE);
                chk(rom_entry == BASE + k * STRIDE + 3, "R6 entry address",
                    rom_entry, BASE + k * STRIDE + 3);
                if (k == 5) begin
                    bit held;
                    held = 1'b1;
                    for (int w = 0; w < 20; w++) begin
                        @(negedge clk);
                        if (!rom_valid || rd_en || rom_base != BASE + k * STRIDE) held = 1'b0;
                    end
                    // R6 report held and reads paused without ack
                    chk(held, "R6 hold without ack", held, 1);
                end
                rom_ack = 1'b1;
                @(negedge clk);
                rom_ack = 1'b0;
                // R6 valid drops after ack
                chk(!rom_valid, "R6 valid after ack", rom_valid, 0);
                @(negedge clk);
                if (k < WCNT - 1) begin
                    // R7 resume at next window, also after a long image
                    chk(rd_en && rd_addr == BASE + (k + 1) * STRIDE, "R7 resume window",
                        rd_addr, BASE + (k + 1) * STRIDE);
                end
            end
        end

        begin
            int guard;
            guard = 0;
            while (!scan_done && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
        end
        // R9 done raised after last window
        chk(scan_done, "R9 done", scan_done, 1);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int w = 0; w < 10; w++) begin
                @(negedge clk);
                if (!scan_done || rd_en || rom_valid) quiet = 1'b0;
            end
            // R9 done sticky, no reads or reports
            chk(quiet, "R9 quiet after done", quiet, 1);
        end
        // R5 only zero-sum images were reported
        chk(reports == 4, "R5 report count", reports, 4);

        for (int k = 0; k < WCNT; k++) begin
            case (kind_of(k))
                1: begin
                    exp_reads = 2;
                    chk(reads[k] == exp_reads, "R3 first marker reads", reads[k], exp_reads);
                end
                4: begin
                    exp_reads = 3;
                    chk(reads[k] == exp_reads, "R3 second marker reads", reads[k], exp_reads);
                end
                3: begin
                    exp_reads = 4;
                    chk(reads[k] == exp_reads, "R4 zero length reads", reads[k], exp_reads);
                end
                default: begin
                    exp_reads = len_of(k) * 512;
                    chk(reads[k] == exp_reads, "R10 image read span", reads[k], exp_reads);
                end
            endcase
        end

        // R1 directed reset after completion
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!scan_done && !rom_valid && !rd_en, "R1 reset clears done",
            {rd_en, rom_valid, scan_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_en && rd_addr == BASE, "R1 restart at base", rd_addr, BASE);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule